// File: doc/BRIEF.md
# Byte Mask and Shuffle Unit

This unit executes two related operations that share a 64-bit status register. The mask-set operation adds two 64-bit integer operands. It returns the full sum as its result and copies the low 32 bits of that sum into the upper half of the status register. The shuffle operation builds a 64-bit result from the 16 bytes of its two operands. Each of the eight result bytes is picked by one 4-bit nibble of the stored mask.

Software sets the permutation once with a mask-set and can then apply it to any number of shuffles. The lower half of the status register is kept as it is and never read. Each accepted operation produces a registered result together with a done pulse that lasts one cycle.

Top module: `byte_shuffle_unit`

## Requirements
- R1: While synchronous reset is high, and after it is released, the status register reads zero, the done flag is low and the result is zero until the first accepted operation.
- R2: An operation with `op_valid` high and code 0x019 (mask-set) registers `opnd_a + opnd_b`, modulo 2^64, onto `res_data` at the next clock edge.
- R3: A mask-set writes bits 31:0 of the sum into status bits 63:32 and leaves status bits 31:0 unchanged.
- R4: An operation with code 0x04C (shuffle) sets result byte i (bits 8i+7:8i) from mask nibble i (status bits 32+4i+3:32+4i). A nibble value n of 0 to 7 selects byte n of `opnd_a`, and a value of 8 to 15 selects byte n-8 of `opnd_b`, with bytes counted from the least significant end.
- R5: A shuffle leaves the whole status register unchanged.
- R6: A shuffle issued in the cycle directly after a mask-set uses the mask that mask-set wrote.
- R7: `res_done` is high for exactly the one cycle after each accepted operation. It stays low after a cycle with `op_valid` low.
- R8: Any code other than 0x019 and 0x04C, even with `op_valid` high, raises no done pulse and changes neither `res_data` nor the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 9 | Operation code |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| res_data | output | 64 | Registered result |
| res_done | output | 1 | One-cycle completion pulse |
| stat_q | output | 64 | Status register; mask in bits 63:32 |

## Verification
A mask-set updates the mask register at the same clock edge that captures the next operation's inputs, so the mask write and the shuffle read meet at a single edge. The bench provokes this by running mask-set and shuffle pairs back to back, with the strobe held high across them. It judges each shuffle against a permutation computed from the mask value the preceding add must produce. Any stale-mask read would give a result different from that permutation.

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit #(
  parameter int          DW   = 64,
  parameter int          OPW  = 9,
  parameter logic [8:0]  MSET = 9'h019,
  parameter logic [8:0]  SHUF = 9'h04C
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  opnd_a,
  input  logic [DW-1:0]  opnd_b,
  output logic [DW-1:0]  res_data,
  output logic           res_done,
  output logic [DW-1:0]  stat_q
);
  localparam int NB    = DW / 8;
  localparam int SELW  = $clog2(2 * NB);
  localparam int MASKW = NB * SELW;

  logic [DW-1:0]    sum;
  logic [2*DW-1:0]  pool;
  logic [MASKW-1:0] mask;
  logic [DW-1:0]    shuf;
  logic             is_mset, is_shuf;

  assign is_mset = op_valid && (op_code == OPW'(MSET));
  assign is_shuf = op_valid && (op_code == OPW'(SHUF));
  assign sum     = opnd_a + opnd_b;
  assign pool    = {opnd_b, opnd_a};
  assign mask    = stat_q[DW-1 -: MASKW];

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [SELW-1:0] sel;
    assign sel = mask[SELW*i +: SELW];
    assign shuf[8*i +: 8] = pool[8*sel +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      res_data <= '0;
      res_done <= 1'b0;
    end else begin
      res_done <= is_mset || is_shuf;
      if (is_mset) begin
        res_data                <= sum;
        stat_q[DW-1 -: MASKW]   <= sum[MASKW-1:0];
      end else if (is_shuf) begin
        res_data <= shuf;
      end
    end
  end
endmodule

module byte_shuffle_unit_chk #(
  parameter int         DW   = 64,
  parameter int         OPW  = 9,
  parameter logic [8:0] MSET = 9'h019,
  parameter logic [8:0] SHUF = 9'h04C
) (
  input logic           clk,
  input logic           rst,
  input logic           op_valid,
  input logic [OPW-1:0] op_code,
  input logic [DW-1:0]  opnd_a,
  input logic [DW-1:0]  opnd_b,
  input logic [DW-1:0]  res_data,
  input logic           res_done,
  input logic [DW-1:0]  stat_q
);
  localparam int HW = DW / 2;
  logic known;
  assign known = op_valid && (op_code == OPW'(MSET) || op_code == OPW'(SHUF));

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (stat_q == '0 && !res_done));
  // R2
  sum_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPW'(MSET)) |=> res_data == $past(opnd_a) + $past(opnd_b));
  // R3
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPW'(MSET)) |=>
      (stat_q[HW-1:0] == $past(stat_q[HW-1:0]) &&
       stat_q[DW-1:HW] == $past(opnd_a[HW-1:0] + opnd_b[HW-1:0])));
  // R5
  shuffle_keeps_status_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OPW'(SHUF)) |=> $stable(stat_q));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) known |=> res_done);
  // R7
  idle_no_done_chk: assert property (@(posedge clk) disable iff (rst) !op_valid |=> !res_done);
  // R8
  unknown_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !known) |=> (!res_done && $stable(res_data) && $stable(stat_q)));
endmodule

bind byte_shuffle_unit byte_shuffle_unit_chk #(.DW(DW), .OPW(OPW), .MSET(MSET), .SHUF(SHUF)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .res_data(res_data),
  .res_done(res_done), .stat_q(stat_q)
);

// File: tb/byte_shuffle_unit_tb.sv
module byte_shuffle_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [8:0]  op_code = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [63:0] res_data, stat_q;
  logic        res_done;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  byte_shuffle_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_data(res_data),
    .res_done(res_done), .stat_q(stat_q)
  );

  typedef struct packed {
    logic [8:0]  op;
    logic [63:0] a, b, res, st;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{9'h019, 64'h0000_0001_7654_3200, 64'h10, 64'h0000_0001_7654_3210, 64'h7654_3210_0000_0000},
    '{9'h04C, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, 64'h8877_6655_4433_2211, 64'h7654_3210_0000_0000},
    '{9'h019, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FEDC_BA99, 64'h0000_0000_FEDC_BA98, 64'hFEDC_BA98_0000_0000},
    '{9'h04C, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, 64'hFFEE_DDCC_BBAA_9988, 64'hFEDC_BA98_0000_0000},
    '{9'h019, 64'h0, 64'h0000_0000_0123_4567, 64'h0000_0000_0123_4567, 64'h0123_4567_0000_0000},
    '{9'h04C, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, 64'h1122_3344_5566_7788, 64'h0123_4567_0000_0000},
    '{9'h019, 64'h0, 64'h0000_0000_F0F0_F0F0, 64'h0000_0000_F0F0_F0F0, 64'hF0F0_F0F0_0000_0000},
    '{9'h04C, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, 64'hFF11_FF11_FF11_FF11, 64'hF0F0_F0F0_0000_0000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic v, input logic [8:0] c, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_valid = v; op_code = c; opnd_a = a; opnd_b = b;
    step();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset values while held
    chk("R1 status in reset", stat_q, 64'h0);
    chk("R1 done in reset", {63'h0, res_done}, 64'h0);
    chk("R1 result in reset", res_data, 64'h0);
    @(negedge clk); rst = 1'b0;
    step();
    chk("R1 status after release", stat_q, 64'h0);

    // R2 R3 R4 R5 R6: vectors run back to back, strobe held high
    for (int k = 0; k < NV; k++) begin
      drive(1'b1, VEC[k].op, VEC[k].a, VEC[k].b);
      chk($sformatf("R7 done vec%0d", k), {63'h0, res_done}, 64'h1);
      chk($sformatf("%s result vec%0d", VEC[k].op == 9'h019 ? "R2" : "R4 R6", k), res_data, VEC[k].res);
      chk($sformatf("%s status vec%0d", VEC[k].op == 9'h019 ? "R3" : "R5", k), stat_q, VEC[k].st);
    end

    // R7 idle cycle clears done and holds result
    drive(1'b0, 9'h04C, 64'h1, 64'h2);
    chk("R7 done idle", {63'h0, res_done}, 64'h0);
    chk("R7 result held idle", res_data, 64'hFF11_FF11_FF11_FF11);

    // R8 unknown code ignored
    drive(1'b1, 9'h04D, 64'hDEAD, 64'hBEEF);
    chk("R8 no done", {63'h0, res_done}, 64'h0);
    chk("R8 result held", res_data, 64'hFF11_FF11_FF11_FF11);
    chk("R8 status held", stat_q, 64'hF0F0_F0F0_0000_0000);

    // R2 R3 carry across bit 31 into upper result, mask becomes zero
    drive(1'b1, 9'h019, 64'hFFFF_FFFF, 64'h1);
    chk("R2 carry sum", res_data, 64'h1_0000_0000);
    chk("R3 mask zero after carry", stat_q, 64'h0);
    // R4 R6 all-zero mask repeats byte 0 of opnd_a
    drive(1'b1, 9'h04C, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988);
    chk("R4 R6 zero mask", res_data, 64'h1111_1111_1111_1111);
    // R4 mask nibble 15 everywhere picks top byte of opnd_b
    drive(1'b1, 9'h019, 64'h0, 64'hFFFF_FFFF);
    drive(1'b1, 9'h04C, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988);
    chk("R4 all-15 mask", res_data, 64'hFFFF_FFFF_FFFF_FFFF);
    drive(1'b0, 9'h0, 64'h0, 64'h0);
    chk("R7 single pulse", {63'h0, res_done}, 64'h0);

    // R1 reset mid-run clears status
    @(negedge clk); rst = 1'b1;
    step();
    chk("R1 status after mid reset", stat_q, 64'h0);
    chk("R1 result after mid reset", res_data, 64'h0);
    @(negedge clk); rst = 1'b0;
    step();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule